// File: doc/BRIEF.md
# SPI Master Burst Sequencer

This block is the shifting core of a byte-wide SPI master. Software programs a 32-bit control word that holds the clock mode, bit order, chip-select choice and polarity, and a receive-discard switch. Setting the start bit runs one burst. A burst clocks a programmed total number of bytes. The first part of that total is pulled from an external transmit FIFO. The rest goes out as zero filler. Every received byte is pushed to an external receive FIFO, unless discard is set, as it is for transmit-only traffic.

The SCK rate is set outside the block. A one-cycle `tick` input marks each SCK half-period, and the sequencer toggles SCK only on ticks. The transmit FIFO connects through a valid/ready pair. The receive side is a one-cycle push strobe, and the FIFO must accept it. When the burst finishes, the start bit clears itself and a completion pulse is raised for one cycle.

Top module: `spi_burst_seq`

## Requirements
- R1: Outside byte shifting, `sclk` rests at control bit 1 (CPOL). Control bit 0 (CPHA) picks the capture edge: with CPHA=0 data is valid before the leading edge and is captured on it; with CPHA=1 data changes on the leading edge and is captured on the trailing edge.
- R2: Each byte takes 16 ticks, and `sclk` changes state only on a tick. With `miso` tied to `mosi`, every received byte equals the byte shifted out.
- R3: Control bit 12 set shifts each byte least-significant bit first. Cleared, each byte shifts most-significant bit first, on both `mosi` and `miso`.
- R4: A burst clocks `burstLen` bytes. The first `txLen` bytes are popped from the transmit FIFO in order, and the remaining bytes are sent as 0x00. `txReady` is raised only while a FIFO byte is due.
- R5: Control bit 8 set suppresses every `rxValid` strobe of the burst.
- R6: Writing the control word with bit 31 set while idle starts a burst. Bit 31 reads back cleared in the cycle in which the one-cycle `donePulse` is seen.
- R7: If the transmit FIFO is empty when a FIFO byte is due, `sclk` holds at its rest level and the chip select stays asserted until data arrives.
- R8: With control bit 6 clear, the line chosen by control bits 5:4 is driven to the active level (control bit 2, 1 = active high) from the start of the burst until one tick after the last SCK edge. It reads inactive, with `sclk` at rest, in the cycle in which `donePulse` is seen.
- R9: With control bit 6 set, the chosen line is driven with control bit 7 directly.
- R10: Chip-select lines that are not chosen always sit at the inverse of control bit 2.
- R11: Control writes made while a burst is running are ignored.
- R12: A start with `burstLen` of 0 raises `donePulse` in the next cycle. It produces no SCK edge and no chip-select assertion.
- R13: After reset the control word reads 0, all chip selects are high, `sclk` is low, and `donePulse`, `rxValid` and `txReady` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlWr | input | 1 | Control word write strobe |
| ctrlWrData | input | 32 | Control word write data |
| burstLen | input | CNT_W | Total bytes of the burst, sampled at start |
| txLen | input | CNT_W | Bytes taken from the transmit FIFO, sampled at start |
| tick | input | 1 | SCK half-period strobe from the external divider |
| txValid | input | 1 | Transmit FIFO has a byte |
| txReady | output | 1 | Pop strobe to the transmit FIFO |
| txData | input | 8 | Transmit FIFO head byte |
| rxValid | output | 1 | Push strobe to the receive FIFO |
| rxData | output | 8 | Received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csOut | output | 4 | Chip-select lines |
| ctrlWord | output | 32 | Control word read-back |
| donePulse | output | 1 | One-cycle burst completion strobe |

## Verification
The bench builds the block with the default 24-bit counter width. It runs bursts of zero to five bytes with `miso` looped back to `mosi`, which covers all four clock modes and both bit orders. The runs include zero-only fill, a fully FIFO-fed burst, and discard on and off. Most runs tick on every cycle, which puts the tail tick and the byte boundaries in adjacent cycles. One run ticks on every third cycle and starts with an empty FIFO, to exercise the stall and the busy-write rejection.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int BYTE_W = 8;
  localparam int HALF_W = $clog2(2 * BYTE_W);
  localparam int CS_NUM = 4;
  localparam int SEL_W  = $clog2(CS_NUM);

  typedef struct packed {
    logic             cpha;
    logic             cpol;
    logic             spol;
    logic [SEL_W-1:0] sel;
    logic             manual;
    logic             level;
    logic             discard;
    logic             lsbFirst;
  } ctrlCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              park;
    logic              loadByte;
    logic [BYTE_W-1:0] loadData;
    logic              halfTick;
  } dpCmd_t;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_TAIL} seqState_t;

  function automatic logic [BYTE_W-1:0] bitRev(input logic [BYTE_W-1:0] d);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = d[BYTE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [31:0]       ctrlWrData,
  input  logic [CNT_W-1:0]  burstLen,
  input  logic [CNT_W-1:0]  txLen,
  input  logic              tick,
  input  logic              txValid,
  input  logic [BYTE_W-1:0] txData,
  input  logic              byteDone,
  output logic              txReady,
  output ctrlCfg_t          cfg,
  output dpCmd_t            cmd,
  output logic [31:0]       ctrlWord,
  output logic [CS_NUM-1:0] csOut,
  output logic              donePulse
);
  localparam logic [31:0] CTRL_MASK = 32'h8000_11F7;
  localparam int          START_BIT = 31;

  logic [31:0]      ctrlQ;
  seqState_t        state;
  logic [CNT_W-1:0] burstQ, txQ, sentCnt;
  logic             doneQ;
  logic             busy, needFifo, idleWr;

  assign cfg.cpha     = ctrlQ[0];
  assign cfg.cpol     = ctrlQ[1];
  assign cfg.spol     = ctrlQ[2];
  assign cfg.sel      = ctrlQ[5:4];
  assign cfg.manual   = ctrlQ[6];
  assign cfg.level    = ctrlQ[7];
  assign cfg.discard  = ctrlQ[8];
  assign cfg.lsbFirst = ctrlQ[12];

  assign busy      = (state != S_IDLE);
  assign needFifo  = (sentCnt < txQ);
  assign idleWr    = ctrlWr && !busy;
  assign ctrlWord  = ctrlQ;
  assign donePulse = doneQ;

  always_comb begin
    cmd      = '0;
    txReady  = 1'b0;
    cmd.park = !busy;
    case (state)
      S_LOAD: begin
        if (!needFifo) begin
          cmd.loadByte = 1'b1;
        end else if (txValid) begin
          txReady      = 1'b1;
          cmd.loadByte = 1'b1;
          cmd.loadData = txData;
        end
      end
      S_SHIFT: cmd.halfTick = tick;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      state   <= S_IDLE;
      burstQ  <= '0;
      txQ     <= '0;
      sentCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (idleWr) begin
        ctrlQ <= ctrlWrData & CTRL_MASK;
        if (ctrlWrData[START_BIT]) begin
          if (burstLen == '0) begin
            ctrlQ[START_BIT] <= 1'b0;
            doneQ            <= 1'b1;
          end else begin
            burstQ  <= burstLen;
            txQ     <= txLen;
            sentCnt <= '0;
            state   <= S_LOAD;
          end
        end
      end
      case (state)
        S_LOAD: begin
          if (cmd.loadByte) begin
            sentCnt <= sentCnt + 1'b1;
            state   <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (byteDone) state <= (sentCnt == burstQ) ? S_TAIL : S_LOAD;
        end
        S_TAIL: begin
          if (tick) begin
            state            <= S_IDLE;
            ctrlQ[START_BIT] <= 1'b0;
            doneQ            <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < CS_NUM; i++) begin : g_cs
    assign csOut[i] = (cfg.sel == SEL_W'(i)) ?
                      (cfg.manual ? cfg.level : (busy ? cfg.spol : ~cfg.spol)) :
                      ~cfg.spol;
  end

  // R4: the tail is entered only after the full burst has been loaded
  p_tail_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TAIL) |-> (sentCnt == burstQ));
  // R6: completion clears the start bit and lasts one cycle
  p_done_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !ctrlQ[START_BIT]);
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  // R11: busy writes leave the control word alone
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && busy && !(state == S_TAIL && tick)) |=> (ctrlQ == $past(ctrlQ)));
  // R8: automatic select stays active during the burst
  p_cs_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cfg.manual) |-> (csOut[cfg.sel] == cfg.spol));
endmodule

// File: rtl/spi_burst_dp.sv
module spi_burst_dp
  import spi_burst_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpha,
  input  logic              cpol,
  input  logic              lsbFirst,
  input  logic              discard,
  input  dpCmd_t            cmd,
  input  logic              miso,
  output logic              byteDone,
  output logic              sclk,
  output logic              mosi,
  output logic              rxValid,
  output logic [BYTE_W-1:0] rxData
);
  localparam logic [HALF_W-1:0] LAST_HALF = HALF_W'(2 * BYTE_W - 1);

  logic [BYTE_W-1:0] txSh, rxSh, rxNext;
  logic [HALF_W-1:0] halfCnt;
  logic              sclkQ, leadEdge, sampleNow, shiftNow;

  assign leadEdge  = ~halfCnt[0];
  assign sampleNow = cmd.halfTick && (leadEdge ^ cpha);
  assign shiftNow  = cmd.halfTick && !(leadEdge ^ cpha) &&
                     (halfCnt != '0) && (halfCnt != LAST_HALF);
  assign byteDone  = cmd.halfTick && (halfCnt == LAST_HALF);
  assign rxNext    = sampleNow ? {rxSh[BYTE_W-2:0], miso} : rxSh;
  assign sclk      = sclkQ;
  assign mosi      = txSh[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh    <= '0;
      rxSh    <= '0;
      halfCnt <= '0;
      sclkQ   <= 1'b0;
      rxValid <= 1'b0;
      rxData  <= '0;
    end else begin
      rxValid <= 1'b0;
      if (cmd.park) sclkQ <= cpol;
      if (cmd.loadByte) begin
        txSh    <= lsbFirst ? bitRev(cmd.loadData) : cmd.loadData;
        halfCnt <= '0;
        sclkQ   <= cpol;
      end
      if (cmd.halfTick) begin
        sclkQ   <= ~sclkQ;
        halfCnt <= halfCnt + 1'b1;
        rxSh    <= rxNext;
        if (shiftNow) txSh <= {txSh[BYTE_W-2:0], 1'b0};
        if (byteDone) begin
          rxValid <= !discard;
          rxData  <= lsbFirst ? bitRev(rxNext) : rxNext;
        end
      end
    end
  end

  // R1: clock rests at the polarity level while parked
  p_park_level_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmd.park |=> (sclk == $past(cpol)));
  // R2: every tick while shifting is one SCK edge
  p_tick_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.halfTick |=> (sclk != $past(sclk)));
  // R7: no edge without a tick (covers the empty-FIFO wait)
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.halfTick && !cmd.park && !cmd.loadByte) |=> $stable(sclk));
  // R5: discarded bursts never push
  p_discard_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !discard);
endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
  import spi_burst_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [31:0]       ctrlWrData,
  input  logic [CNT_W-1:0]  burstLen,
  input  logic [CNT_W-1:0]  txLen,
  input  logic              tick,
  input  logic              txValid,
  output logic              txReady,
  input  logic [BYTE_W-1:0] txData,
  output logic              rxValid,
  output logic [BYTE_W-1:0] rxData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_NUM-1:0] csOut,
  output logic [31:0]       ctrlWord,
  output logic              donePulse
);
  ctrlCfg_t cfg;
  dpCmd_t   cmd;
  logic     byteDone;

  spi_burst_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData),
    .burstLen(burstLen), .txLen(txLen), .tick(tick), .txValid(txValid),
    .txData(txData), .byteDone(byteDone), .txReady(txReady), .cfg(cfg),
    .cmd(cmd), .ctrlWord(ctrlWord), .csOut(csOut), .donePulse(donePulse)
  );

  spi_burst_dp u_dp (
    .clk(clk), .rstN(rstN), .cpha(cfg.cpha), .cpol(cfg.cpol),
    .lsbFirst(cfg.lsbFirst), .discard(cfg.discard), .cmd(cmd), .miso(miso),
    .byteDone(byteDone), .sclk(sclk), .mosi(mosi), .rxValid(rxValid),
    .rxData(rxData)
  );
endmodule

// File: tb/spi_burst_seq_test.sv
module spi_burst_seq_test;
  localparam int CNT_W = 24;
  // vector: [44:40] {spol,discard,lsb,cpol,cpha} [33:32] sel [31:24] burst [23:16] txLen [7:0] seed
  localparam int NVEC = 6;
  localparam logic [47:0] VEC [NVEC] = '{
    48'h00_00_03_03_00_A5,
    48'h01_01_04_02_00_3C,
    48'h06_02_02_02_00_81,
    48'h1B_03_03_03_00_5E,
    48'h04_00_05_00_00_00,
    48'h15_01_04_04_00_C7
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic ctrlWr = 1'b0;
  logic [31:0] ctrlWrData = '0;
  logic [CNT_W-1:0] burstLen = '0, txLen = '0;
  logic tick, txValid, txReady, rxValid, sclk, mosi, miso;
  logic [7:0] txData, rxData;
  logic [3:0] csOut;
  logic [31:0] ctrlWord;
  logic donePulse;

  int nChk = 0, nFail = 0;
  int tickDiv = 1;
  logic [3:0] tickPh;
  int txIdx = 0, avail = 0;
  logic curCpha = 0, curCpol = 0, curSpol = 0, curLsb = 0, curDisc = 0;
  int curSel = 0, curBurst = 0, curTx = 0;
  logic [7:0] curSeed = '0;
  int capIdx = 0, capBad = 0, rxIdx = 0, rxBad = 0, csBad = 0, slaveBits = 0;
  logic [7:0] slaveSh = '0;
  logic prevSclk = 1'b0;

  always #4 clk = ~clk;

  spi_burst_seq #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData),
    .burstLen(burstLen), .txLen(txLen), .tick(tick), .txValid(txValid),
    .txReady(txReady), .txData(txData), .rxValid(rxValid), .rxData(rxData),
    .sclk(sclk), .mosi(mosi), .miso(miso), .csOut(csOut),
    .ctrlWord(ctrlWord), .donePulse(donePulse)
  );

  assign miso = mosi;
  assign tick = (tickPh == 4'd0);
  assign txValid = (txIdx < avail);
  assign txData = pat(curSeed, txIdx);

  function automatic logic [7:0] pat(input logic [7:0] s, input int k);
    return s + 8'(k * 29);
  endfunction
  function automatic logic [7:0] rev8(input logic [7:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = d[7-i];
    return r;
  endfunction
  function automatic logic [7:0] expByte(input int k);
    return (k < curTx) ? pat(curSeed, k) : 8'h00;
  endfunction

  always @(posedge clk or negedge rstN)
    if (!rstN) tickPh <= '0;
    else tickPh <= (int'(tickPh) >= tickDiv - 1) ? 4'd0 : tickPh + 4'd1;

  always @(posedge clk) if (txValid && txReady) txIdx <= txIdx + 1;

  // slave model and line monitor
  always @(negedge clk) begin
    if (csOut[curSel] == curSpol) begin
      for (int j = 0; j < 4; j++)
        if (j != curSel && csOut[j] != !curSpol) csBad++;
      if (sclk != prevSclk && sclk == (curCpol == curCpha)) begin
        slaveSh = {slaveSh[6:0], mosi};
        slaveBits++;
        if (slaveBits == 8) begin
          if (slaveSh != (curLsb ? rev8(expByte(capIdx)) : expByte(capIdx))) capBad++;
          capIdx++;
          slaveBits = 0;
        end
      end
    end
    if (rxValid) begin
      if (rxData != expByte(rxIdx)) rxBad++;
      rxIdx++;
    end
    prevSclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeCtrl(input logic [31:0] d);
    @(negedge clk);
    ctrlWr = 1'b1;
    ctrlWrData = d;
    @(negedge clk);
    ctrlWr = 1'b0;
  endtask

  task automatic clearMon();
    capIdx = 0; capBad = 0; rxIdx = 0; rxBad = 0; csBad = 0; slaveBits = 0;
    txIdx = 0;
  endtask

  task automatic waitDone(output bit seen);
    int w = 0;
    seen = 0;
    while (!donePulse && w < 5000) begin
      @(negedge clk);
      w++;
    end
    seen = donePulse;
  endtask

  function automatic logic [31:0] mkCtrl();
    return 32'(curCpha) | (32'(curCpol) << 1) | (32'(curSpol) << 2) |
           (32'(curSel) << 4) | (32'(curDisc) << 8) | (32'(curLsb) << 12);
  endfunction

  task automatic runVec(input logic [47:0] v);
    logic [31:0] cw;
    bit seen;
    curCpha = v[40]; curCpol = v[41]; curLsb = v[42]; curDisc = v[43]; curSpol = v[44];
    curSel = int'(v[33:32]); curBurst = int'(v[31:24]); curTx = int'(v[23:16]);
    curSeed = v[7:0];
    cw = mkCtrl();
    burstLen = CNT_W'(curBurst);
    txLen = CNT_W'(curTx);
    avail = 1000;
    writeCtrl(cw);
    @(negedge clk);
    clearMon();
    writeCtrl(cw | 32'h8000_0000);
    waitDone(seen);
    chk(seen, "R6 done pulse seen", int'(seen), 1);
    chk(ctrlWord == cw, "R6 start bit cleared at done", int'(ctrlWord), int'(cw));
    chk(csOut[curSel] == !curSpol, "R8 select released at done", int'(csOut[curSel]), int'(!curSpol));
    chk(sclk == curCpol, "R1 sclk at rest after burst", int'(sclk), int'(curCpol));
    @(negedge clk);
    chk(!donePulse, "R6 done lasts one cycle", int'(donePulse), 0);
    chk(capIdx == curBurst && capBad == 0, "R2 R3 R4 line bytes (count/bad)",
        capIdx * 256 + capBad, curBurst * 256);
    chk(rxIdx == (curDisc ? 0 : curBurst) && rxBad == 0, "R5 R2 received bytes (count/bad)",
        rxIdx * 256 + rxBad, (curDisc ? 0 : curBurst) * 256);
    chk(txIdx == curTx, "R4 FIFO pops", txIdx, curTx);
    chk(csBad == 0, "R10 unselected lines inactive", csBad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic [31:0] cw;
    bit seen, moved, csLost;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(ctrlWord == 0, "R13 control word", int'(ctrlWord), 0);
    chk(csOut == 4'hF, "R13 chip selects", int'(csOut), 15);
    chk(sclk == 0 && !donePulse && !rxValid && !txReady, "R13 outputs low",
        int'({sclk, donePulse, rxValid, txReady}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) runVec(VEC[i]);

    // R12 zero-length burst
    curSel = 0; curSpol = 0; curCpol = 0; curCpha = 0; curLsb = 0; curDisc = 0;
    burstLen = '0; txLen = '0;
    clearMon();
    writeCtrl(32'h8000_0000);
    chk(donePulse, "R12 immediate done", int'(donePulse), 1);
    chk(ctrlWord == 0 && csOut == 4'hF, "R12 no start bit, no select",
        int'(ctrlWord[31]) * 16 + int'(csOut), 15);
    @(negedge clk);
    chk(!donePulse && capIdx == 0, "R12 single pulse, no edges", int'(donePulse), 0);

    // R7 / R11 empty FIFO stall with gapped ticks and busy write
    tickDiv = 3;
    curSel = 1; curSeed = 8'h42; curBurst = 2; curTx = 2;
    cw = mkCtrl();
    burstLen = 24'd2; txLen = 24'd2; avail = 0;
    writeCtrl(cw);
    @(negedge clk);
    clearMon();
    writeCtrl(cw | 32'h8000_0000);
    moved = 0; csLost = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (sclk != 1'b0) moved = 1;
      if (csOut[1] != 1'b0) csLost = 1;
    end
    chk(!moved, "R7 sclk held while FIFO empty", int'(moved), 0);
    chk(!csLost && !donePulse, "R7 select held, no done", int'(csLost), 0);
    writeCtrl(32'h0000_0002);
    avail = 2;
    waitDone(seen);
    chk(seen && capIdx == 2 && capBad == 0, "R7 bytes after FIFO refill",
        capIdx * 256 + capBad, 512);
    chk(ctrlWord == cw, "R11 busy write ignored", int'(ctrlWord), int'(cw));
    tickDiv = 1;

    // R9 / R10 manual select
    curSel = 2; curSpol = 0;
    writeCtrl(32'h0000_0060);
    @(negedge clk);
    chk(csOut == 4'b1011, "R9 manual level 0", int'(csOut), 11);
    writeCtrl(32'h0000_00E4);
    @(negedge clk);
    chk(csOut == 4'b0100, "R9 R10 manual level 1, active-high others", int'(csOut), 4);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule